// File: doc/BRIEF.md
# Service Routine Entry and Return Sequencer

This block carries a 16-bit, two-privilege processor into and out of service routines. Three causes start an entry: a device interrupt accepted at the start of an instruction fetch, a return-from-service instruction attempted in user mode, and an undefined opcode. All three follow one path. The old status word is staged and the mode bit is cleared. The stack pointers are exchanged if the caller ran in user mode. The status word and then the return address (PC minus one) are pushed on the supervisor stack. The handler address is then read from a table at 0x0100 plus an 8-bit vector.

The return-from-service instruction, issued in supervisor mode, pops PC and then the status word. If the restored status word selects user mode, the sequencer swaps the stack pointers back. The status word, PC and stack-pointer register (R6) stay outside the block. The sequencer reads their current values and drives a write strobe and a new value for each. The saved user and supervisor stack pointers are kept inside the block. Memory is reached through a request port that holds each access until the memory answers with ready.

Top module: `svc_entry_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `mem_en`, `psr_we`, `pc_we` and `r6_we` are all 0, the saved supervisor stack pointer equals parameter SSP_RST and the saved user stack pointer equals USP_RST.
- R2: An interrupt request is accepted only in a cycle where `fetch_start` is 1. A request without `fetch_start` leaves the block idle and writes nothing.
- R3: On entry the status word (bit 15 = user mode, bits 10:8 = priority, bits 2:0 = N/Z/P) has bit 15 cleared. An interrupt replaces bits 10:8 with `irq_prio`. The two exceptions leave the priority unchanged, and every other bit is kept.
- R4: On entry from user mode, R6 is saved as the user stack pointer and R6 is loaded from the saved supervisor stack pointer before any push. From supervisor mode the pushes start at the current R6. A privilege violation always takes the swap path.
- R5: Each push decrements R6 and then writes memory at the new R6. The old status word goes to R6-1 and the value PC-1 goes to R6-2, so R6 ends two words below the starting supervisor stack.
- R6: PC is loaded with the memory word at 0x0100 + vector. The vector is `irq_vec` for an interrupt, 0x00 for a return attempted in user mode and 0x01 for an undefined opcode.
- R7: A return in supervisor mode loads PC from memory at R6 and the status word from memory at R6+1, and leaves R6 two higher. If the restored bit 15 is 1, that R6 is saved as the supervisor stack pointer and R6 is loaded from the saved user stack pointer.
- R8: While `mem_en` is 1 and `mem_rdy` is 0, the request (`mem_addr`, `mem_we`, `mem_wdata`) is held unchanged in the next cycle. Writes occur only in supervisor mode, at the address held in R6.
- R9: `done` is 1 for exactly one cycle at the end of each sequence, and `busy` is 0 in the following cycle.
- R10: Start requests that arrive while a sequence is running are ignored. The running sequence finishes with its own result, and no second sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_start | input | 1 | Processor is in its fetch-start cycle |
| irq_req | input | 1 | Interrupt request above current priority |
| irq_prio | input | 3 | Priority of the requester |
| irq_vec | input | 8 | Vector of the requester |
| rti_dec | input | 1 | Return-from-service instruction decoded |
| ill_dec | input | 1 | Undefined opcode decoded |
| cur_psr | input | 16 | Current status word |
| cur_pc | input | 16 | Current PC (already incremented) |
| cur_r6 | input | 16 | Current stack-pointer register |
| psr_we | output | 1 | Status word write strobe |
| psr_d | output | 16 | New status word |
| pc_we | output | 1 | PC write strobe |
| pc_d | output | 16 | New PC |
| r6_we | output | 1 | R6 write strobe |
| r6_d | output | 16 | New R6 |
| mem_en | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with ready |
| mem_rdy | input | 1 | Access completes this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last cycle of a sequence |

## Verification
The assertions check on every cycle that a pending memory request is held still, that every write is a supervisor-mode write at the address in R6, and that PC is loaded only on a completed read. They also check that an idle cycle with no qualifying start stays idle, and that `busy` drops after `done`. The bench scenarios are needed for the values themselves. These are the stack contents and their order, the handler address for each vector, the priority rule, and the exchange of saved stack pointers across a sequence of mode changes, where a value saved in one sequence is used in a later one.

// File: rtl/svc_pkg.sv
package svc_pkg;
  typedef enum logic [1:0] {K_INT, K_PRIV, K_ILL, K_RET} kind_t;
  typedef enum logic [3:0] {
    S_IDLE, S_ENTRY, S_SWAP, S_PDEC, S_PWR, S_VRD, S_POPPC, S_POPPSR, S_RSWAP
  } st_t;
  localparam int PRIV_BIT = 15;
  localparam int PRIO_LSB = 8;
endpackage

// File: rtl/svc_cause_sel.sv
module svc_cause_sel
  import svc_pkg::*;
#(
  parameter int VW       = 8,
  parameter int PW       = 3,
  parameter int PRIV_VEC = 0,
  parameter int ILL_VEC  = 1
) (
  input  logic          fetch_start,
  input  logic          irq_req,
  input  logic [PW-1:0] irq_prio,
  input  logic [VW-1:0] irq_vec,
  input  logic          rti_dec,
  input  logic          ill_dec,
  input  logic          in_user,
  output logic          start,
  output kind_t         kind,
  output logic [VW-1:0] vec,
  output logic [PW-1:0] prio
);
  // Interrupt at fetch start wins, then undefined opcode, then return.
  always_comb begin
    start = 1'b0;
    kind  = K_INT;
    vec   = irq_vec;
    prio  = irq_prio;
    if (fetch_start && irq_req) begin
      start = 1'b1;
    end else if (ill_dec) begin
      start = 1'b1;
      kind  = K_ILL;
      vec   = VW'(ILL_VEC);
    end else if (rti_dec) begin
      start = 1'b1;
      kind  = in_user ? K_PRIV : K_RET;
      vec   = VW'(PRIV_VEC);
    end
  end
endmodule

// File: rtl/svc_sp_bank.sv
module svc_sp_bank #(
  parameter int             DW      = 16,
  parameter logic [DW-1:0]  SSP_RST = 16'h0300,
  parameter logic [DW-1:0]  USP_RST = 16'h03F0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          usp_ld,
  input  logic          ssp_ld,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] usp_q,
  output logic [DW-1:0] ssp_q
);
  logic [DW-1:0] usp_d, ssp_d;

  always_comb begin
    usp_d = usp_ld ? din : usp_q;
    ssp_d = ssp_ld ? din : ssp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usp_q <= USP_RST;
      ssp_q <= SSP_RST;
    end else begin
      if (usp_ld) usp_q <= usp_d;
      if (ssp_ld) ssp_q <= ssp_d;
    end
  end
endmodule

// File: rtl/svc_ctrl.sv
module svc_ctrl
  import svc_pkg::*;
#(
  parameter int            DW       = 16,
  parameter int            VW       = 8,
  parameter int            PW       = 3,
  parameter logic [DW-1:0] VEC_BASE = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  kind_t         kind_in,
  input  logic [VW-1:0] vec_in,
  input  logic [PW-1:0] prio_in,
  input  logic [DW-1:0] cur_psr,
  input  logic [DW-1:0] cur_pc,
  input  logic [DW-1:0] cur_r6,
  input  logic [DW-1:0] usp_q,
  input  logic [DW-1:0] ssp_q,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rdy,
  output logic          psr_we,
  output logic [DW-1:0] psr_d,
  output logic          pc_we,
  output logic [DW-1:0] pc_d,
  output logic          r6_we,
  output logic [DW-1:0] r6_d,
  output logic          usp_ld,
  output logic          ssp_ld,
  output logic          mem_en,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          done
);
  localparam logic [DW-1:0] ONE = DW'(1);

  st_t           st_q, st_d;
  kind_t         kind_q;
  logic [VW-1:0] vec_q;
  logic [PW-1:0] prio_q;
  logic [DW-1:0] stage_q, stage_d, mar_q, mar_d;
  logic          phase_q, phase_d;
  logic          cap_en;

  assign cap_en = (st_q == S_IDLE) && start;
  assign busy   = (st_q != S_IDLE);

  always_comb begin
    st_d      = st_q;
    stage_d   = stage_q;
    mar_d     = mar_q;
    phase_d   = phase_q;
    psr_we    = 1'b0;
    psr_d     = cur_psr;
    pc_we     = 1'b0;
    pc_d      = cur_pc;
    r6_we     = 1'b0;
    r6_d      = cur_r6;
    usp_ld    = 1'b0;
    ssp_ld    = 1'b0;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = mar_q;
    mem_wdata = stage_q;
    done      = 1'b0;
    unique case (st_q)
      S_IDLE: if (start) st_d = (kind_in == K_RET) ? S_POPPC : S_ENTRY;
      S_ENTRY: begin
        psr_we             = 1'b1;
        psr_d[PRIV_BIT]    = 1'b0;
        if (kind_q == K_INT) psr_d[PRIO_LSB +: PW] = prio_q;
        stage_d            = cur_psr;
        phase_d            = 1'b0;
        st_d = (kind_q == K_PRIV || cur_psr[PRIV_BIT]) ? S_SWAP : S_PDEC;
      end
      S_SWAP: begin
        usp_ld = 1'b1;
        r6_we  = 1'b1;
        r6_d   = ssp_q;
        st_d   = S_PDEC;
      end
      S_PDEC: begin
        r6_we = 1'b1;
        r6_d  = cur_r6 - ONE;
        mar_d = cur_r6 - ONE;
        st_d  = S_PWR;
      end
      S_PWR: begin
        mem_en = 1'b1;
        mem_we = 1'b1;
        if (mem_rdy) begin
          if (!phase_q) begin
            stage_d = cur_pc - ONE;
            phase_d = 1'b1;
            st_d    = S_PDEC;
          end else begin
            st_d = S_VRD;
          end
        end
      end
      S_VRD: begin
        mem_en   = 1'b1;
        mem_addr = VEC_BASE + DW'(vec_q);
        if (mem_rdy) begin
          pc_we = 1'b1;
          pc_d  = mem_rdata;
          done  = 1'b1;
          st_d  = S_IDLE;
        end
      end
      S_POPPC: begin
        mem_en   = 1'b1;
        mem_addr = cur_r6;
        if (mem_rdy) begin
          pc_we = 1'b1;
          pc_d  = mem_rdata;
          r6_we = 1'b1;
          r6_d  = cur_r6 + ONE;
          st_d  = S_POPPSR;
        end
      end
      S_POPPSR: begin
        mem_en   = 1'b1;
        mem_addr = cur_r6;
        if (mem_rdy) begin
          psr_we = 1'b1;
          psr_d  = mem_rdata;
          r6_we  = 1'b1;
          r6_d   = cur_r6 + ONE;
          done   = !mem_rdata[PRIV_BIT];
          st_d   = mem_rdata[PRIV_BIT] ? S_RSWAP : S_IDLE;
        end
      end
      S_RSWAP: begin
        ssp_ld = 1'b1;
        r6_we  = 1'b1;
        r6_d   = usp_q;
        done   = 1'b1;
        st_d   = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      kind_q  <= K_INT;
      vec_q   <= '0;
      prio_q  <= '0;
      stage_q <= '0;
      mar_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      stage_q <= stage_d;
      mar_q   <= mar_d;
      phase_q <= phase_d;
      if (cap_en) begin
        kind_q <= kind_in;
        vec_q  <= vec_in;
        prio_q <= prio_in;
      end
    end
  end
endmodule

// File: rtl/svc_entry_seq.sv
module svc_entry_seq
  import svc_pkg::*;
#(
  parameter int             DW       = 16,
  parameter int             VW       = 8,
  parameter int             PW       = 3,
  parameter logic [DW-1:0]  VEC_BASE = 16'h0100,
  parameter int             PRIV_VEC = 0,
  parameter int             ILL_VEC  = 1,
  parameter logic [DW-1:0]  SSP_RST  = 16'h0300,
  parameter logic [DW-1:0]  USP_RST  = 16'h03F0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_start,
  input  logic          irq_req,
  input  logic [PW-1:0] irq_prio,
  input  logic [VW-1:0] irq_vec,
  input  logic          rti_dec,
  input  logic          ill_dec,
  input  logic [DW-1:0] cur_psr,
  input  logic [DW-1:0] cur_pc,
  input  logic [DW-1:0] cur_r6,
  output logic          psr_we,
  output logic [DW-1:0] psr_d,
  output logic          pc_we,
  output logic [DW-1:0] pc_d,
  output logic          r6_we,
  output logic [DW-1:0] r6_d,
  output logic          mem_en,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rdy,
  output logic          busy,
  output logic          done
);
  logic          start, usp_ld, ssp_ld;
  kind_t         kind;
  logic [VW-1:0] vec;
  logic [PW-1:0] prio;
  logic [DW-1:0] usp_q, ssp_q;

  svc_cause_sel #(.VW(VW), .PW(PW), .PRIV_VEC(PRIV_VEC), .ILL_VEC(ILL_VEC)) u_sel (
    .fetch_start(fetch_start), .irq_req(irq_req), .irq_prio(irq_prio),
    .irq_vec(irq_vec), .rti_dec(rti_dec), .ill_dec(ill_dec),
    .in_user(cur_psr[PRIV_BIT]), .start(start), .kind(kind), .vec(vec), .prio(prio)
  );

  svc_sp_bank #(.DW(DW), .SSP_RST(SSP_RST), .USP_RST(USP_RST)) u_sp (
    .clk(clk), .rst_n(rst_n), .usp_ld(usp_ld), .ssp_ld(ssp_ld),
    .din(cur_r6), .usp_q(usp_q), .ssp_q(ssp_q)
  );

  svc_ctrl #(.DW(DW), .VW(VW), .PW(PW), .VEC_BASE(VEC_BASE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .kind_in(kind), .vec_in(vec),
    .prio_in(prio), .cur_psr(cur_psr), .cur_pc(cur_pc), .cur_r6(cur_r6),
    .usp_q(usp_q), .ssp_q(ssp_q), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .psr_we(psr_we), .psr_d(psr_d), .pc_we(pc_we), .pc_d(pc_d),
    .r6_we(r6_we), .r6_d(r6_d), .usp_ld(usp_ld), .ssp_ld(ssp_ld),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .done(done)
  );
endmodule

// File: rtl/svc_entry_seq_chk.sv
module svc_entry_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_start,
  input logic          rti_dec,
  input logic          ill_dec,
  input logic          in_user,
  input logic [DW-1:0] cur_r6,
  input logic          pc_we,
  input logic          mem_en,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_rdy,
  input logic          busy,
  input logic          done
);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_rdy) |=> (mem_en && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R8
  push_super_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (!in_user && mem_addr == cur_r6));

  // R6
  pc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> (mem_en && !mem_we && mem_rdy));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !fetch_start && !rti_dec && !ill_dec) |=> !busy);

  // R1
  idle_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> busy);

  // R9
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

bind svc_entry_seq svc_entry_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_start(fetch_start), .rti_dec(rti_dec),
  .ill_dec(ill_dec), .in_user(cur_psr[15]), .cur_r6(cur_r6), .pc_we(pc_we),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_rdy(mem_rdy), .busy(busy), .done(done)
);

// File: tb/test_svc_entry_seq.sv
`timescale 1ns/1ps
module test_svc_entry_seq;
  localparam int LAT = 5;
  localparam logic [15:0] SSP0 = 16'h0300;
  localparam logic [15:0] USP0 = 16'h03F0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fetch_start = 0, irq_req = 0, rti_dec = 0, ill_dec = 0;
  logic [2:0] irq_prio = '0;
  logic [7:0] irq_vec = '0;
  logic [15:0] psr_r, pc_r, r6_r;
  logic psr_we, pc_we, r6_we, mem_en, mem_we, mem_rdy, busy, done;
  logic [15:0] psr_d, pc_d, r6_d, mem_addr, mem_wdata, mem_rdata;
  logic [15:0] mem [0:1023];
  logic [3:0] cnt;
  logic pk_en = 0, ld = 0;
  logic [15:0] pk_a = '0, pk_d = '0, ld_psr = '0, ld_pc = '0, ld_r6 = '0;
  int checks = 0, errors = 0;
  logic [15:0] ssp_exp = SSP0, usp_exp = USP0;
  logic held_q = 0;
  logic [15:0] haddr_q = '0, hdata_q = '0;

  always #2 clk = ~clk;

  svc_entry_seq i_svc_entry_seq (
    .clk(clk), .rst_n(rst_n), .fetch_start(fetch_start), .irq_req(irq_req),
    .irq_prio(irq_prio), .irq_vec(irq_vec), .rti_dec(rti_dec), .ill_dec(ill_dec),
    .cur_psr(psr_r), .cur_pc(pc_r), .cur_r6(r6_r), .psr_we(psr_we), .psr_d(psr_d),
    .pc_we(pc_we), .pc_d(pc_d), .r6_we(r6_we), .r6_d(r6_d), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .busy(busy), .done(done)
  );

  // Processor registers and five-cycle memory model
  assign mem_rdy   = mem_en && (cnt == 4'(LAT - 1));
  assign mem_rdata = mem[mem_addr[9:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      psr_r <= 16'h0002; pc_r <= 16'h3000; r6_r <= SSP0; cnt <= '0;
    end else begin
      if (ld) begin psr_r <= ld_psr; pc_r <= ld_pc; r6_r <= ld_r6; end
      else begin
        if (psr_we) psr_r <= psr_d;
        if (pc_we)  pc_r  <= pc_d;
        if (r6_we)  r6_r  <= r6_d;
      end
      cnt <= (mem_en && !mem_rdy) ? cnt + 4'd1 : 4'd0;
    end
    if (pk_en) mem[pk_a[9:0]] <= pk_d;
    else if (mem_en && mem_rdy && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
  end

  function automatic logic [15:0] vt(input logic [7:0] v);
    return 16'h4005 + (16'(v) << 4);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // R8: pending request must stay put
  always @(negedge clk) begin
    if (rst_n && held_q) begin
      chk("R8 held request", {mem_addr ^ haddr_q} | {mem_wdata ^ hdata_q} | 16'(!mem_en), 16'h0);
    end
    held_q  <= mem_en && !mem_rdy;
    haddr_q <= mem_addr;
    hdata_q <= mem_wdata;
  end

  task automatic poke(input logic [15:0] a, input logic [15:0] d);
    pk_en = 1; pk_a = a; pk_d = d;
    @(negedge clk);
    pk_en = 0;
  endtask

  task automatic setregs(input logic [15:0] p, input logic [15:0] c, input logic [15:0] s);
    ld = 1; ld_psr = p; ld_pc = c; ld_r6 = s;
    @(negedge clk);
    ld = 0;
  endtask

  task automatic fire(input int c, input logic [7:0] v, input logic [2:0] pr, input bit noise);
    int n;
    case (c)
      0: begin fetch_start = 1; irq_req = 1; irq_vec = v; irq_prio = pr; end
      1: ill_dec = 1;
      default: rti_dec = 1;
    endcase
    @(negedge clk);
    fetch_start = 0; irq_req = 0; ill_dec = 0; rti_dec = 0;
    n = 0;
    while (!done && n < 300) begin
      if (noise && n == 2) begin
        fetch_start = 1; irq_req = 1; ill_dec = 1; rti_dec = 1; irq_vec = v + 8'd9;
      end else if (noise && n == 3) begin
        fetch_start = 0; irq_req = 0; ill_dec = 0; rti_dec = 0;
      end
      @(negedge clk);
      n++;
    end
    if (n >= 300) chk("R9 sequence finished", 16'h0, 16'h1);
    @(negedge clk);
    chk("R9 busy low after done", 16'(busy), 16'h0);
    chk("R9 done single cycle", 16'(done), 16'h0);
  endtask

  // c: 0 interrupt, 1 undefined opcode, 2 return attempted in user mode
  task automatic do_entry(input int c, input logic [7:0] v, input logic [2:0] pr, input bit noise);
    logic [15:0] op, opc, sp, ep;
    logic [7:0] ev;
    op = psr_r; opc = pc_r;
    if (op[15]) begin usp_exp = r6_r; sp = ssp_exp; end else sp = r6_r;
    ev = (c == 0) ? v : (c == 1) ? 8'h01 : 8'h00;
    ep = {1'b0, op[14:11], (c == 0) ? pr : op[10:8], op[7:0]};
    fire(c, v, pr, noise);
    chk($sformatf("R3 psr cause %0d", c), psr_r, ep);
    chk($sformatf("R4 R5 final r6 cause %0d", c), r6_r, sp - 16'd2);
    chk($sformatf("R5 pushed psr cause %0d", c), mem[10'(sp - 16'd1)], op);
    chk($sformatf("R5 pushed pc-1 cause %0d", c), mem[10'(sp - 16'd2)], opc - 16'd1);
    chk($sformatf("R6 handler pc cause %0d", c), pc_r, vt(ev));
  endtask

  // R7: return from supervisor with a prepared frame
  task automatic do_rti(input logic [15:0] npc, input logic [15:0] npsr);
    logic [15:0] er6;
    poke(r6_r, npc);
    poke(r6_r + 16'd1, npsr);
    er6 = r6_r + 16'd2;
    if (npsr[15]) begin ssp_exp = er6; er6 = usp_exp; end
    fire(2, 8'h0, 3'h0, 1'b0);
    chk("R7 popped pc", pc_r, npc);
    chk("R7 popped psr", psr_r, npsr);
    chk("R7 final r6", r6_r, er6);
  endtask

  function automatic logic [15:0] rnd_psr(input bit user);
    logic [2:0] cc;
    cc = 3'b001 << ($urandom % 3);
    return {user, 4'b0, 3'($urandom), 5'b0, cc};
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL R9 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy in reset", 16'(busy), 16'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy after reset", 16'(busy), 16'h0);
    chk("R1 strobes after reset", {12'h0, mem_en, psr_we, pc_we, r6_we}, 16'h0);
    chk("R1 done after reset", 16'(done), 16'h0);
    for (int i = 0; i < 256; i++) poke(16'h0100 + 16'(i), vt(8'(i)));

    // R2: request without fetch start is ignored
    irq_req = 1; irq_vec = 8'h20; irq_prio = 3'd5;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R2 ignored request busy", 16'(busy | mem_en | psr_we | pc_we | r6_we), 16'h0);
    end
    irq_req = 0;
    chk("R2 pc unchanged", pc_r, 16'h3000);

    // Directed: supervisor interrupt, undefined opcode, R1 saved-pointer reset values
    do_entry(0, 8'h80, 3'd4, 1'b0);
    do_entry(1, 8'h00, 3'd0, 1'b0);
    // R1 / R7: return to user takes R6 from the reset user pointer
    setregs(16'h0601, 16'h3100, r6_r);
    do_rti(16'h3456, 16'h8302);
    chk("R1 reset user pointer used", r6_r, USP0);
    // R4: interrupt from user swaps stacks
    do_entry(0, 8'h81, 3'd6, 1'b0);
    // R6 / R4: return in user mode becomes a privilege violation
    setregs(16'h0002, 16'h3200, r6_r);
    do_rti(16'h3300, 16'h8104);
    do_entry(2, 8'h00, 3'd0, 1'b0);
    // R10: starts while busy are ignored
    do_entry(0, 8'h42, 3'd7, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10 no second sequence", 16'(busy), 16'h0);
    end

    // Random walk over causes and modes
    for (int k = 0; k < 40; k++) begin
      int c;
      c = int'($urandom % 3);
      setregs(rnd_psr(psr_r[15]), 16'($urandom) | 16'h0001, r6_r);
      if (c == 2 && !psr_r[15])
        do_rti(16'($urandom), rnd_psr(1'($urandom)));
      else
        do_entry(c, 8'($urandom), 3'($urandom), 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule